// File: doc/BRIEF.md
# Status Word and Register Bank Unit

This unit keeps the processor status byte and the stack pointer for a small 8-bit microcontroller datapath. Seven of the eight status bits are held in flip-flops. Software can write them, and separate strobes from the arithmetic logic can set the carry, auxiliary-carry and overflow bits. The lowest bit is never stored. It is the parity of the accumulator value presented on the input, and it follows that input combinationally, so a read always shows parity for the current accumulator.

Two bits of the status byte choose one of four working-register banks. The unit turns a 3-bit working-register number into an internal-RAM byte address inside the selected bank, so the decoder never has to know which bank is active.

The stack pointer resets to 07h. A push pre-increments it and presents the new value as the write address in the same cycle. A pop presents the current value as the read address and then decrements it. Instruction decoding, the RAM array and the ALU sit outside this unit.

Top module: `status_bank_unit`

## Requirements
- R1: After reset the stored status bits read as zero and the stack address output shows 07h while no push or pop is requested.
- R2: Bit 0 of the status read port is 1 exactly when the accumulator input holds an odd number of ones, so that bit 0 plus the accumulator's ones-count is even. It follows the accumulator within the same cycle.
- R3: A status write stores bits 7 to 1 of the write data, and they appear on the read port from the next cycle on. Bit 0 of the write data is ignored. With no write and no strobe the stored bits hold.
- R4: The carry, auxiliary-carry and overflow strobes load their value into bit 7, bit 6 and bit 2 respectively at the next edge. If a strobe and a status write fall in the same cycle, the strobe's value wins for that bit.
- R5: The register address output equals {000, status bit 4, status bit 3, register number}. Bank 00 therefore maps R0–R7 to 00h–07h, bank 01 to 08h–0Fh, bank 10 to 10h–17h and bank 11 to 18h–1Fh.
- R6: On a push the stack address output shows the stack pointer plus one in that cycle, and the pointer takes that value at the edge. The first push after reset addresses 08h.
- R7: On a pop without a push the stack address output shows the current pointer, and the pointer then decrements by one.
- R8: When push and pop are requested together, the push is performed and the pop is ignored.
- R9: With no request the stack address output shows the pointer and the pointer holds. Increment and decrement wrap modulo 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_i | input | 8 | Current accumulator value |
| sw_wr_en | input | 1 | Status byte write enable |
| sw_wr_data | input | 8 | Status byte write data |
| sw_rd_data | output | 8 | Status byte read data, bit 0 is live parity |
| cy_upd | input | 1 | Carry update strobe |
| cy_val | input | 1 | Carry value |
| ac_upd | input | 1 | Auxiliary carry update strobe |
| ac_val | input | 1 | Auxiliary carry value |
| ov_upd | input | 1 | Overflow update strobe |
| ov_val | input | 1 | Overflow value |
| reg_num | input | 3 | Working register number |
| reg_addr | output | 8 | Internal RAM address of the working register |
| push_req | input | 1 | Push request |
| pop_req | input | 1 | Pop request |
| stk_addr | output | 8 | Stack access address |

## Verification
Parity is tried with an empty accumulator, single-bit values, all-ones and mixed values. This separates an even/odd inversion from a stuck or a partial reduction. Bank mapping walks all eight register numbers in each of the four banks, which exposes swapped or misplaced bank bits. Stack traffic covers the first push after reset, push runs, pop runs, simultaneous requests and a decrement through zero, so pre- and post-increment ordering, priority and wrap each show up on their own. A long random phase mixes writes, strobes and stack requests, and a behavioural model is compared on every clock.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  localparam int unsigned SW_W      = 8;
  localparam int unsigned BIT_CY    = 7;
  localparam int unsigned BIT_AC    = 6;
  localparam int unsigned BIT_F0    = 5;
  localparam int unsigned BIT_BK_HI = 4;
  localparam int unsigned BIT_BK_LO = 3;
  localparam int unsigned BIT_OV    = 2;
  localparam int unsigned BIT_UF    = 1;
  localparam int unsigned BIT_PAR   = 0;
  localparam int unsigned BANK_W    = BIT_BK_HI - BIT_BK_LO + 1;

  function automatic logic odd_ones(input logic [SW_W-1:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/sbu_rst_sync.sv
module sbu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sbu_status_reg.sv
module sbu_status_reg
  import sbu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SW_W-1:0]   acc_i,
  input  logic              wr_en,
  input  logic [SW_W-1:0]   wr_data,
  input  logic              cy_upd,
  input  logic              cy_val,
  input  logic              ac_upd,
  input  logic              ac_val,
  input  logic              ov_upd,
  input  logic              ov_val,
  output logic [SW_W-1:0]   sw_o,
  output logic [BANK_W-1:0] bank_o
);
  logic [SW_W-1:1] flags_q;
  logic [SW_W-1:1] flags_d;
  logic            load_en;
  logic            par;

  always_comb begin
    flags_d = flags_q;
    if (wr_en)  flags_d = wr_data[SW_W-1:1];
    if (cy_upd) flags_d[BIT_CY] = cy_val;
    if (ac_upd) flags_d[BIT_AC] = ac_val;
    if (ov_upd) flags_d[BIT_OV] = ov_val;
    load_en = wr_en | cy_upd | ac_upd | ov_upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= '0;
    else if (load_en) flags_q <= flags_d;
  end

  assign par    = odd_ones(acc_i);
  assign sw_o   = {flags_q, par};
  assign bank_o = flags_q[BIT_BK_HI:BIT_BK_LO];

  AST_WR_LOADS_F0: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sw_o[BIT_F0] == $past(wr_data[BIT_F0])) else $error("status write lost"); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en | cy_upd | ac_upd | ov_upd) |=> $stable(sw_o[SW_W-1:1])) else $error("status drifted"); // R3
  AST_CY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cy_upd |=> sw_o[BIT_CY] == $past(cy_val)) else $error("carry strobe lost"); // R4
  AST_OV_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ov_upd |=> sw_o[BIT_OV] == $past(ov_val)) else $error("overflow strobe lost"); // R4
  AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(acc_i) + int'(sw_o[BIT_PAR])) % 2 == 0) else $error("parity odd"); // R2
endmodule

// File: rtl/sbu_bank_map.sv
module sbu_bank_map #(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ADDR_W = 8
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned PAD_W = ADDR_W - BANK_W - IDX_W;

  generate
    if (PAD_W == 0) begin : g_nopad
      assign addr_o = {bank_i, idx_i};
    end else begin : g_pad
      assign addr_o = {{PAD_W{1'b0}}, bank_i, idx_i};
    end
  endgenerate
endmodule

// File: rtl/sbu_stack_ptr.sv
module sbu_stack_ptr #(
  parameter int unsigned   W      = 8,
  parameter logic [W-1:0]  SP_RST = 8'h07
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  output logic [W-1:0] addr_o
);
  localparam logic [W-1:0] ONE = 1;

  logic [W-1:0] sp_q;
  logic [W-1:0] sp_d;
  logic [W-1:0] sp_inc;
  logic [W-1:0] sp_dec;
  logic         sp_en;

  always_comb begin
    sp_inc = sp_q + ONE;
    sp_dec = sp_q - ONE;
    sp_d   = sp_q;
    sp_en  = 1'b0;
    addr_o = sp_q;
    if (push) begin
      sp_d   = sp_inc;
      sp_en  = 1'b1;
      addr_o = sp_inc;
    end else if (pop) begin
      sp_d  = sp_dec;
      sp_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= SP_RST;
    else if (sp_en) sp_q <= sp_d;
  end

  AST_PUSH_INC: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sp_q == $past(sp_q) + ONE) else $error("push did not increment"); // R6
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> sp_q == $past(sp_q) - ONE) else $error("pop did not decrement"); // R7
  AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(sp_q)) else $error("pointer moved when idle"); // R9
  AST_PUSH_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> sp_q != $past(sp_q) - ONE) else $error("pop won over push"); // R8
endmodule

// File: rtl/status_bank_unit.sv
module status_bank_unit
  import sbu_pkg::*;
#(
  parameter int unsigned  IDX_W  = 3,
  parameter int unsigned  ADDR_W = 8,
  parameter logic [7:0]   SP_RST = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SW_W-1:0]   acc_i,
  input  logic              sw_wr_en,
  input  logic [SW_W-1:0]   sw_wr_data,
  output logic [SW_W-1:0]   sw_rd_data,
  input  logic              cy_upd,
  input  logic              cy_val,
  input  logic              ac_upd,
  input  logic              ac_val,
  input  logic              ov_upd,
  input  logic              ov_val,
  input  logic [IDX_W-1:0]  reg_num,
  output logic [ADDR_W-1:0] reg_addr,
  input  logic              push_req,
  input  logic              pop_req,
  output logic [ADDR_W-1:0] stk_addr
);
  logic              rst_core_n;
  logic [BANK_W-1:0] bank;

  sbu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  sbu_status_reg u_status (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .acc_i   (acc_i),
    .wr_en   (sw_wr_en),
    .wr_data (sw_wr_data),
    .cy_upd  (cy_upd),
    .cy_val  (cy_val),
    .ac_upd  (ac_upd),
    .ac_val  (ac_val),
    .ov_upd  (ov_upd),
    .ov_val  (ov_val),
    .sw_o    (sw_rd_data),
    .bank_o  (bank)
  );

  sbu_bank_map #(.IDX_W(IDX_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_bank (
    .bank_i (bank),
    .idx_i  (reg_num),
    .addr_o (reg_addr)
  );

  sbu_stack_ptr #(.W(ADDR_W), .SP_RST(SP_RST)) u_sp (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .push   (push_req),
    .pop    (pop_req),
    .addr_o (stk_addr)
  );

  AST_BANK_WINDOW: assert property (@(posedge clk) disable iff (!rst_core_n)
    reg_addr[IDX_W+BANK_W-1:IDX_W] == sw_rd_data[BIT_BK_HI:BIT_BK_LO]) else $error("bank not applied"); // R5
endmodule

// File: tb/status_bank_unit_tb.sv
module status_bank_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] acc_i, sw_wr_data, sw_rd_data, reg_addr, stk_addr;
  logic       sw_wr_en, cy_upd, cy_val, ac_upd, ac_val, ov_upd, ov_val;
  logic [2:0] reg_num;
  logic       push_req, pop_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] m_sw;
  logic [7:0] m_sp;

  always #10 clk = ~clk;

  status_bank_unit u_dut (
    .clk(clk), .rst_n(rst_n), .acc_i(acc_i),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .sw_rd_data(sw_rd_data),
    .cy_upd(cy_upd), .cy_val(cy_val), .ac_upd(ac_upd), .ac_val(ac_val),
    .ov_upd(ov_upd), .ov_val(ov_val), .reg_num(reg_num), .reg_addr(reg_addr),
    .push_req(push_req), .pop_req(pop_req), .stk_addr(stk_addr)
  );

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    sw_wr_en = 0; sw_wr_data = 0; cy_upd = 0; cy_val = 0; ac_upd = 0; ac_val = 0;
    ov_upd = 0; ov_val = 0; push_req = 0; pop_req = 0;
  endtask

  // inputs already set after a negedge; compare, clock, update model
  task automatic cyc(input string tag);
    logic [7:0] e_sw, e_reg, e_stk;
    #2;
    e_sw  = {m_sw[7:1], ^acc_i};
    e_reg = {3'b000, m_sw[4:3], reg_num};
    e_stk = push_req ? m_sp + 8'd1 : m_sp;
    chk(tag, "sw_rd_data", sw_rd_data, e_sw);
    chk(tag, "reg_addr", reg_addr, e_reg);
    chk(tag, "stk_addr", stk_addr, e_stk);
    @(posedge clk);
    #1;
    if (sw_wr_en) m_sw = sw_wr_data & 8'hFE;
    if (cy_upd) m_sw[7] = cy_val;
    if (ac_upd) m_sw[6] = ac_val;
    if (ov_upd) m_sw[2] = ov_val;
    if (push_req)     m_sp = m_sp + 8'd1;
    else if (pop_req) m_sp = m_sp - 8'd1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; acc_i = 0; reg_num = 0; idle();
    m_sw = 8'h00; m_sp = 8'h07;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    cyc("R1");
    // R6 first push after reset lands at 08h
    push_req = 1; cyc("R6");
    push_req = 1; cyc("R6");
    idle(); cyc("R9");
    // R7 pops
    pop_req = 1; cyc("R7");
    pop_req = 1; cyc("R7");
    // R8 simultaneous
    push_req = 1; pop_req = 1; cyc("R8");
    idle(); cyc("R8");
    // R9 wrap through zero by popping
    for (int i = 0; i < 10; i++) begin pop_req = 1; cyc("R9"); end
    idle(); cyc("R9");
    push_req = 1; cyc("R9");
    idle();

    // R2 parity patterns
    foreach (acc_i[i]) begin acc_i = 8'h01 << i; cyc("R2"); end
    acc_i = 8'h00; cyc("R2");
    acc_i = 8'hFF; cyc("R2");
    acc_i = 8'h03; cyc("R2");
    acc_i = 8'h7F; cyc("R2");
    acc_i = 8'hA5; cyc("R2");

    // R3 write ignores bit 0
    acc_i = 8'h00;
    sw_wr_en = 1; sw_wr_data = 8'hFF; cyc("R3");
    idle(); cyc("R3");
    sw_wr_en = 1; sw_wr_data = 8'h01; cyc("R3");
    idle(); cyc("R3");

    // R4 strobes and priority over a write
    sw_wr_en = 1; sw_wr_data = 8'h00; cy_upd = 1; cy_val = 1; cyc("R4");
    idle(); cyc("R4");
    sw_wr_en = 1; sw_wr_data = 8'hFF; ac_upd = 1; ac_val = 0; ov_upd = 1; ov_val = 0; cyc("R4");
    idle(); cyc("R4");
    ov_upd = 1; ov_val = 1; cy_upd = 1; cy_val = 0; cyc("R4");
    idle(); cyc("R4");

    // R5 every bank, every register
    for (int b = 0; b < 4; b++) begin
      sw_wr_en = 1; sw_wr_data = 8'(b << 3); cyc("R5");
      idle();
      for (int r = 0; r < 8; r++) begin reg_num = 3'(r); cyc("R5"); end
    end

    // random mix
    for (int n = 0; n < 400; n++) begin
      acc_i = 8'($urandom); reg_num = 3'($urandom);
      sw_wr_en = ($urandom % 4) == 0; sw_wr_data = 8'($urandom);
      cy_upd = ($urandom % 3) == 0; cy_val = 1'($urandom);
      ac_upd = ($urandom % 3) == 0; ac_val = 1'($urandom);
      ov_upd = ($urandom % 3) == 0; ov_val = 1'($urandom);
      push_req = 1'($urandom); pop_req = 1'($urandom);
      cyc("RND");
    end
    idle(); cyc("R9");
    finish_run();
  end
endmodule